// File: doc/BRIEF.md
# Wishbone Address Window Bridge

This block is a Wishbone slave that claims one aligned window of the host address space. It passes every access inside that window to an attached peripheral bus. That bus has separate read and write strobes, a word offset, a write-data output, a read-data input and an acknowledge input.

Both strobes follow the host cycle combinationally. A strobe rises in the same cycle that CYC and STB present an address in the window, and it falls as soon as the host drops either of them. The offset and write data are driven only while a strobe is high, and are zero otherwise.

Completion comes from one of two sources, chosen by a parameter. In immediate mode the bridge acknowledges by itself one clock edge after the access starts. In deferred mode the peripheral acknowledge is relayed, gated by the live cycle.

Top module: `wb_addr_window_bridge`

## Requirements
- R1: A read (we low) with cyc and stb high that hits the window raises perRd in the same cycle. It drives perAddr with the word offset `wbAdr[OFFS_W+1:2]` and routes perRdata to wbDatR.
- R2: A write (we high) with cyc and stb high that hits the window raises perWr in the same cycle. It drives the word offset on perAddr and wbDatW on perWdata.
- R3: perRd and perWr are never high together. Neither strobe rises for an address outside the window, and such an access gets no acknowledge.
- R4: When no strobe is high, perAddr and perWdata are zero. perWdata is also zero during a read. wbDatR is zero whenever perRd is low.
- R5: In immediate mode (IMM_ACK=1), wbAck is low in the first cycle of an access that hits the window. It is high after the next rising edge and lasts one cycle. perAck has no effect in this mode.
- R6: In deferred mode (IMM_ACK=0), wbAck equals perAck while a cycle that hits the window is live, and is low otherwise.
- R7: When either cyc or stb is low, both strobes and wbAck are low in that same cycle.
- R8: A hit means that `wbAdr[31:7]` equals `BASE[31:7]` (defaults: 32-bit address, 5-bit offset). The two byte bits `wbAdr[1:0]` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wbCyc | input | 1 | Host cycle valid |
| wbStb | input | 1 | Host strobe |
| wbWe | input | 1 | Host write enable |
| wbAdr | input | ADDR_W | Host byte address |
| wbDatW | input | DATA_W | Host write data |
| wbDatR | output | DATA_W | Read data to host |
| wbAck | output | 1 | Acknowledge to host |
| perRd | output | 1 | Peripheral read strobe |
| perWr | output | 1 | Peripheral write strobe |
| perAddr | output | OFFS_W | Peripheral word offset |
| perWdata | output | DATA_W | Peripheral write data |
| perRdata | input | DATA_W | Peripheral read data |
| perAck | input | 1 | Peripheral acknowledge (deferred mode) |

## Verification
The assertions check four properties on every cycle:
- the strobes are mutually exclusive;
- the strobes and the acknowledge vanish when the host drops cyc or stb;
- the idle peripheral outputs are zero;
- the acknowledge is a single-cycle pulse in immediate mode and a gated relay of the peripheral acknowledge in deferred mode.

Some behaviour only the bench scenarios can show. Two instances, one in each acknowledge mode, run side by side on the same accesses. The bench confirms the correct offset and data values and the exact window boundaries, including the byte bits being ignored. It also confirms the cycle in which the immediate acknowledge appears, and that a peripheral acknowledge is ignored in immediate mode.

// File: rtl/wbwin_pkg.sv
package wbwin_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic rdEn;
    logic wrEn;
  } winStrobe_t;
endpackage

// File: rtl/wbwin_ctrl.sv
module wbwin_ctrl
  import wbwin_pkg::*;
#(
  parameter int TAG_W = 25,
  parameter logic [TAG_W-1:0] BASE_TAG = '0,
  parameter bit IMM_ACK = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cyc,
  input  logic             stb,
  input  logic             we,
  input  logic [TAG_W-1:0] adrTag,
  input  logic             perAck,
  output winStrobe_t       strb,
  output logic             ack
);
  logic hit;
  logic active;

  assign hit    = (adrTag == BASE_TAG);
  assign active = cyc & stb & hit;

  assign strb.rdEn = active & ~we;
  assign strb.wrEn = active & we;

  generate
    if (IMM_ACK) begin : g_imm
      logic ackQ;
      logic unusedPerAck;
      assign unusedPerAck = perAck;
      always_ff @(posedge clk) begin
        if (rst) ackQ <= 1'b0;
        else     ackQ <= active & ~ackQ;
      end
      assign ack = ackQ & active;

      // R5: immediate acknowledge is a single-cycle pulse
      p_ack_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);
    end else begin : g_defer
      assign ack = perAck & active;

      // R6: peripheral acknowledge is relayed during a live hit
      p_ack_relay_r6: assert property (@(posedge clk) disable iff (rst)
        (perAck && cyc && stb && hit) |-> ack);
    end
  endgenerate

  // R3: strobes exclusive
  p_strobe_excl_r3: assert property (@(posedge clk) disable iff (rst)
    !(strb.rdEn && strb.wrEn));

  // R7: dropping cyc or stb clears strobes
  p_drop_clears_r7: assert property (@(posedge clk) disable iff (rst)
    !(cyc && stb) |-> (!strb.rdEn && !strb.wrEn && !ack));
endmodule

// File: rtl/wbwin_dp.sv
module wbwin_dp
  import wbwin_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int OFFS_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  winStrobe_t        strb,
  input  logic [OFFS_W-1:0] offs,
  input  logic [DATA_W-1:0] wdat,
  input  logic [DATA_W-1:0] perRdata,
  output logic [OFFS_W-1:0] perAddr,
  output logic [DATA_W-1:0] perWdata,
  output logic [DATA_W-1:0] wbDatR
);
  logic anyEn;
  assign anyEn = strb.rdEn | strb.wrEn;

  always_comb begin
    perAddr  = anyEn     ? offs     : '0;
    perWdata = strb.wrEn ? wdat     : '0;
    wbDatR   = strb.rdEn ? perRdata : '0;
  end

  // R4: idle peripheral lines are zero
  p_idle_zero_r4: assert property (@(posedge clk) disable iff (rst)
    !(strb.rdEn || strb.wrEn) |-> (perAddr == '0 && perWdata == '0 && wbDatR == '0));
endmodule

// File: rtl/wb_addr_window_bridge.sv
module wb_addr_window_bridge
  import wbwin_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int OFFS_W = 5,
  parameter logic [ADDR_W-1:0] BASE = 32'h0000_4000,
  parameter bit IMM_ACK = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wbCyc,
  input  logic              wbStb,
  input  logic              wbWe,
  input  logic [ADDR_W-1:0] wbAdr,
  input  logic [DATA_W-1:0] wbDatW,
  output logic [DATA_W-1:0] wbDatR,
  output logic              wbAck,
  output logic              perRd,
  output logic              perWr,
  output logic [OFFS_W-1:0] perAddr,
  output logic [DATA_W-1:0] perWdata,
  input  logic [DATA_W-1:0] perRdata,
  input  logic              perAck
);
  localparam int LSB_W  = $clog2(DATA_W / 8);
  localparam int TAG_LO = OFFS_W + LSB_W;
  localparam int TAG_W  = ADDR_W - TAG_LO;
  localparam logic [TAG_W-1:0] BASE_TAG = BASE[ADDR_W-1:TAG_LO];

  winStrobe_t strb;
  logic       unusedByteBits;
  assign unusedByteBits = ^wbAdr[LSB_W-1:0];

  wbwin_ctrl #(
    .TAG_W(TAG_W), .BASE_TAG(BASE_TAG), .IMM_ACK(IMM_ACK)
  ) u_ctrl (
    .clk(clk), .rst(rst), .cyc(wbCyc), .stb(wbStb), .we(wbWe),
    .adrTag(wbAdr[ADDR_W-1:TAG_LO]), .perAck(perAck),
    .strb(strb), .ack(wbAck)
  );

  wbwin_dp #(.DATA_W(DATA_W), .OFFS_W(OFFS_W)) u_dp (
    .clk(clk), .rst(rst), .strb(strb),
    .offs(wbAdr[TAG_LO-1:LSB_W]), .wdat(wbDatW), .perRdata(perRdata),
    .perAddr(perAddr), .perWdata(perWdata), .wbDatR(wbDatR)
  );

  assign perRd = strb.rdEn;
  assign perWr = strb.wrEn;

  // R6: acknowledge only inside a live cycle
  p_ack_gated_r6: assert property (@(posedge clk) disable iff (rst)
    wbAck |-> (wbCyc && wbStb));

  // R3: no strobe pair at the ports
  p_port_excl_r3: assert property (@(posedge clk) disable iff (rst)
    !(perRd && perWr));
endmodule

// File: tb/wb_addr_window_bridge_bench.sv
module wb_addr_window_bridge_bench;
  localparam logic [31:0] BASE = 32'h0000_4000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cyc = 0, stb = 0, we = 0, pAck = 0;
  logic [31:0] adr = '0, datW = '0, pRd = '0;

  logic [31:0] dRI, wdI, dRD, wdD;
  logic [4:0]  addrI, addrD;
  logic rdI, wrI, ackI, rdD, wrD, ackD;

  int nCmp = 0;
  int nBad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  wb_addr_window_bridge #(.BASE(BASE), .IMM_ACK(1'b1)) u_wb_addr_window_bridge (
    .clk(clk), .rst(rst), .wbCyc(cyc), .wbStb(stb), .wbWe(we), .wbAdr(adr),
    .wbDatW(datW), .wbDatR(dRI), .wbAck(ackI), .perRd(rdI), .perWr(wrI),
    .perAddr(addrI), .perWdata(wdI), .perRdata(pRd), .perAck(pAck));

  wb_addr_window_bridge #(.BASE(BASE), .IMM_ACK(1'b0)) u_wb_addr_window_bridge_defer (
    .clk(clk), .rst(rst), .wbCyc(cyc), .wbStb(stb), .wbWe(we), .wbAdr(adr),
    .wbDatW(datW), .wbDatR(dRD), .wbAck(ackD), .perRd(rdD), .perWr(wrD),
    .perAddr(addrD), .perWdata(wdD), .perRdata(pRd), .perAck(pAck));

  function automatic logic expHit(input logic [31:0] a);
    return a[31:7] == BASE[31:7];
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkIdle(input string tag);
    chk({tag, " R7 rd"}, {31'b0, rdI}, 0);
    chk({tag, " R7 wr"}, {31'b0, wrI}, 0);
    chk({tag, " R7 ackI"}, {31'b0, ackI}, 0);
    chk({tag, " R7 ackD"}, {31'b0, ackD}, 0);
    chk({tag, " R4 addr"}, {27'b0, addrI}, 0);
    chk({tag, " R4 wdata"}, wdI, 0);
    chk({tag, " R4 rdata"}, dRI, 0);
  endtask

  task automatic runCycle(input logic w, input logic [31:0] a, input logic [31:0] d,
                          input logic [31:0] r, input logic pa);
    logic h;
    @(negedge clk);
    cyc = 1; stb = 1; we = w; adr = a; datW = d; pRd = r; pAck = pa;
    #1;
    h = expHit(a);
    chk("R1 perRd", {31'b0, rdI}, {31'b0, h && !w});
    chk("R2 perWr", {31'b0, wrI}, {31'b0, h && w});
    chk("R3 defer strobes", {30'b0, rdD, wrD}, {30'b0, h && !w, h && w});
    chk("R1 R2 R8 perAddr", {27'b0, addrI}, h ? {27'b0, a[6:2]} : 32'b0);
    chk("R2 R4 perWdata", wdI, (h && w) ? d : 32'b0);
    chk("R1 R4 wbDatR", dRI, (h && !w) ? r : 32'b0);
    chk("R5 ack low first cycle", {31'b0, ackI}, 0);
    chk("R6 defer ack", {31'b0, ackD}, {31'b0, h && pa});
    @(posedge clk); #1;
    chk("R5 imm ack after edge", {31'b0, ackI}, {31'b0, h});
    chk("R3 miss no ack defer", {31'b0, ackD}, {31'b0, h && pa});
    @(negedge clk);
    cyc = 0; stb = 0; pAck = 0;
    #1;
    checkIdle("drop");
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    // Reset with a hit presented: R5 acknowledge stays low
    cyc = 1; stb = 1; we = 0; adr = BASE;
    repeat (3) @(posedge clk);
    #1;
    chk("R5 no ack in reset", {31'b0, ackI}, 0);
    @(negedge clk); cyc = 0; stb = 0; rst = 0;
    #1;
    checkIdle("reset");

    // Directed corners
    runCycle(1'b0, BASE, 32'h0, 32'hDEAD_BEEF, 1'b0);          // R1 first word
    runCycle(1'b1, BASE + 32'h7C, 32'hCAFE_0001, 32'h0, 1'b1); // R2 last word
    runCycle(1'b0, BASE + 32'h80, 32'h0, 32'h1234_5678, 1'b1); // R8 above window
    runCycle(1'b1, BASE - 32'h4, 32'h5555_AAAA, 32'h0, 1'b1);  // R8 below window
    runCycle(1'b0, BASE + 32'h13, 32'h0, 32'hA5A5_0F0F, 1'b1); // R8 byte bits ignored
    runCycle(1'b1, BASE + 32'h22, 32'hFFFF_FFFF, 32'h0, 1'b0); // R6 no peripheral ack

    // R7: cyc high, stb low
    @(negedge clk); cyc = 1; stb = 0; we = 1; adr = BASE + 32'h8; pAck = 1;
    #1; checkIdle("cyc only");
    @(posedge clk); #1;
    chk("R7 no imm ack without stb", {31'b0, ackI}, 0);
    @(negedge clk); cyc = 0; pAck = 0;

    // R7: stb high, cyc low
    @(negedge clk); cyc = 0; stb = 1; we = 0; adr = BASE; pAck = 1;
    #1; checkIdle("stb only");
    @(negedge clk); stb = 0; pAck = 0;

    // Random mix
    for (int i = 0; i < 300; i++) begin
      logic [31:0] a;
      a = $urandom;
      if ($urandom_range(0, 2) != 0) a = {BASE[31:7], a[6:0]};
      runCycle(1'($urandom_range(0, 1)), a, $urandom, $urandom,
               1'($urandom_range(0, 1)));
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule